// File: doc/BRIEF.md
# PATA PIO Cycle Strobe Timer

This block drives the active-low read and write strobes of parallel ATA programmed-I/O cycles for a host with two channels of two devices each. Every device, called a unit (unit = 2 × channel + device), owns a 16-bit timing word. The low byte times read cycles and the high byte times write cycles. In each byte the low nibble holds 17 minus the active strobe width and the high nibble holds 16 minus the recovery time, both counted in clocks. The counters load these nibbles directly and count up to a fixed end value, so no subtraction is needed when a cycle starts.

A byte-wide register port writes and reads the timing bytes, a shared per-unit enable byte and a read-only write-buffer status byte. Setting a unit's enable bit marks it as DMA-capable, or as not needing IORDY. While the bit is clear, a low IORDY during the active phase stretches the strobe. A write to the enable byte is held back while either write-buffer busy flag is set. It lands in the first cycle in which both flags are clear. A cycle request gives the channel, the device and the direction. The timer latches that unit's timing when it accepts the request, so register writes made during a cycle only affect later cycles.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset both strobes are high, busy and done are low, every timing byte reads 0x00 (active 17, recovery 16) and the enable byte reads 0x00.
- R2: The timing word of unit n is byte-addressed at 0x20 + 2n (low byte, read timing) and 0x21 + 2n (high byte, write timing). Each byte reads back exactly the value last written to it.
- R3: A read request accepted at a clock edge drives diorN low for 17 − L[3:0] clocks and then high for 16 − L[7:4] recovery clocks, where L is the unit's low timing byte. diowN stays high throughout.
- R4: A write request uses the high timing byte H in the same way on diowN, and diorN stays high.
- R5: busy is high from the clock after acceptance until recovery ends. done is then high for exactly one clock with busy low. A request presented while busy is ignored.
- R6: The unit used is 2 × reqChan + reqDev, and each of the four units uses only its own timing word.
- R7: If a unit's enable bit (bit 4 + unit of the enable byte at 0x0C) is clear, every clock edge that samples iordy low during the active phase stretches the active phase by one clock.
- R8: If a unit's enable bit is set, iordy has no effect on that unit's strobe width.
- R9: The status byte at 0x0D reads back wrBufBusy in bits 1:0. A write to 0x0C made while either busy bit is set does not change the enable byte until both bits are clear. The value then appears on the next clock edge.
- R10: A timing write made during a cycle, or at the very edge that accepts a request, does not change that cycle. It governs the next cycle.
- R11: The extreme encodings work: nibble 0xF gives an active width of 2 and a recovery of 1, and nibble 0x0 gives 17 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| wrBufBusy | input | 2 | Write-buffer busy flags |
| reqValid | input | 1 | Cycle request, taken when busy is low |
| reqChan | input | 1 | Channel of the request |
| reqDev | input | 1 | Device within the channel |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| iordy | input | 1 | Device ready; low extends the active phase |
| busy | output | 1 | A cycle is in its active or recovery phase |
| done | output | 1 | One-clock pulse after recovery ends |
| diorN | output | 1 | Active-low read strobe |
| diowN | output | 1 | Active-low write strobe |

## Verification
Two events can fall in the same cycle: a timing register write and the acceptance of a request for the same unit. The bench provokes this by driving regWrEn and reqValid in the same clock for unit 0's read byte. It then judges the result by measuring the strobe-low and recovery lengths of that cycle, which must match the old byte, and of the next cycle, which must match the new one. A second overlap puts the release of a held enable write next to the cycle that follows it, and is judged by whether the following cycle honours IORDY.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACTIVE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;       // latch the requested unit's timing, load active count
    logic loadRecover;  // load the recovery count
    logic countEn;      // advance the counter
    logic inRecover;    // selects which end value terminates the count
  } pio_ctl_s;

  localparam logic [4:0] ACTIVE_END  = 5'd16;
  localparam logic [4:0] RECOVER_END = 5'd15;

endpackage

// File: rtl/pio_timer_datapath.sv
module pio_timer_datapath
  import pio_timer_pkg::*;
#(
  parameter int NUM_UNITS    = 4,
  parameter int DEV_PER_CHAN = 2,
  parameter int CHAN_W       = 1,
  parameter int DEV_W        = 1,
  parameter int ADDR_W       = 8,
  parameter int TIMING_BASE  = 32,
  parameter int ENABLE_ADDR  = 12,
  parameter int STATUS_ADDR  = 13,
  parameter int ENABLE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [1:0]        wrBufBusy,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic              reqWrite,
  input  logic              iordy,
  input  pio_ctl_s          ctl,
  output logic              cntDone,
  output logic              stall,
  output logic              curWrite
);

  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(ENABLE_ADDR);
  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);

  logic [15:0] timingW [NUM_UNITS];
  logic [7:0]  enQ, pendQ;
  logic        pendV;
  logic [4:0]  cntQ;
  logic [3:0]  curRecNib;
  logic        curHonour;
  logic        bufBusy;

  assign bufBusy = |wrBufBusy;

  // per-unit timing words
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(TIMING_BASE + 2 * g);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(TIMING_BASE + 2 * g + 1);
    logic [15:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ <= '0;
      end else if (regWrEn) begin
        if (regAddr == LO_A) wordQ[7:0]  <= regWrData;
        if (regAddr == HI_A) wordQ[15:8] <= regWrData;
      end
    end
    assign timingW[g] = wordQ;
  end

  // enable byte with write held while write buffers are busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      pendQ <= '0;
      pendV <= 1'b0;
    end else if (regWrEn && regAddr == EN_A) begin
      if (bufBusy) begin
        pendQ <= regWrData;
        pendV <= 1'b1;
      end else begin
        enQ   <= regWrData;
        pendV <= 1'b0;
      end
    end else if (pendV && !bufBusy) begin
      enQ   <= pendQ;
      pendV <= 1'b0;
    end
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (regAddr == ADDR_W'(TIMING_BASE + 2 * u))     regRdData = timingW[u][7:0];
      if (regAddr == ADDR_W'(TIMING_BASE + 2 * u + 1)) regRdData = timingW[u][15:8];
    end
    if (regAddr == EN_A) regRdData = enQ;
    if (regAddr == ST_A) regRdData = {6'b0, wrBufBusy};
  end

  // request decode
  logic [UNIT_W-1:0] reqUnit;
  logic [15:0]       selWord;
  logic [7:0]        selByte;
  logic [7:0]        enShifted;

  assign reqUnit   = UNIT_W'(reqChan) * UNIT_W'(DEV_PER_CHAN) + UNIT_W'(reqDev);
  assign selWord   = timingW[reqUnit];
  assign selByte   = reqWrite ? selWord[15:8] : selWord[7:0];
  assign enShifted = enQ >> (ENABLE_SHIFT + int'(reqUnit));

  // cycle latch and complemented-reload counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      curRecNib <= '0;
      curHonour <= 1'b0;
      curWrite  <= 1'b0;
    end else begin
      if (ctl.accept) begin
        cntQ      <= {1'b0, selByte[3:0]};
        curRecNib <= selByte[7:4];
        curHonour <= ~enShifted[0];
        curWrite  <= reqWrite;
      end else if (ctl.loadRecover) begin
        cntQ <= {1'b0, curRecNib};
      end else if (ctl.countEn) begin
        cntQ <= cntQ + 5'd1;
      end
    end
  end

  assign cntDone = ctl.inRecover ? (cntQ == RECOVER_END) : (cntQ == ACTIVE_END);
  assign stall   = curHonour && !iordy;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= ACTIVE_END);

  assert_enable_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    bufBusy |=> $stable(enQ) || $past(regWrEn && regAddr == EN_A) == 1'b0 && $stable(enQ));

  assert_cycle_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.accept |=> $stable(curRecNib) && $stable(curWrite) && $stable(curHonour));

endmodule

// File: rtl/pio_timer_ctrl.sv
module pio_timer_ctrl
  import pio_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     cntDone,
  input  logic     stall,
  input  logic     curWrite,
  output pio_ctl_s ctl,
  output logic     busy,
  output logic     done,
  output logic     diorN,
  output logic     diowN
);

  phase_e phaseQ, phaseD;
  logic   doneQ, doneD;

  always_comb begin
    phaseD          = phaseQ;
    doneD           = 1'b0;
    ctl             = '0;
    ctl.inRecover   = (phaseQ == PH_RECOVER);
    unique case (phaseQ)
      PH_IDLE: begin
        if (reqValid) begin
          ctl.accept = 1'b1;
          phaseD     = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (!stall) begin
          if (cntDone) begin
            ctl.loadRecover = 1'b1;
            phaseD          = PH_RECOVER;
          end else begin
            ctl.countEn = 1'b1;
          end
        end
      end
      PH_RECOVER: begin
        if (cntDone) begin
          phaseD = PH_IDLE;
          doneD  = 1'b1;
        end else begin
          ctl.countEn = 1'b1;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      doneQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      doneQ  <= doneD;
    end
  end

  assign busy  = (phaseQ != PH_IDLE);
  assign done  = doneQ;
  assign diorN = !((phaseQ == PH_ACTIVE) && !curWrite);
  assign diowN = !((phaseQ == PH_ACTIVE) && curWrite);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  assert_iordy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_ACTIVE && stall) |=> (phaseQ == PH_ACTIVE));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN));

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timer_pkg::*;
#(
  parameter int NUM_CHAN     = 2,
  parameter int DEV_PER_CHAN = 2,
  parameter int ADDR_W       = 8,
  parameter int TIMING_BASE  = 32,
  parameter int ENABLE_ADDR  = 12,
  parameter int STATUS_ADDR  = 13,
  parameter int ENABLE_SHIFT = 4,
  localparam int NUM_UNITS   = NUM_CHAN * DEV_PER_CHAN,
  localparam int CHAN_W      = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int DEV_W       = (DEV_PER_CHAN > 1) ? $clog2(DEV_PER_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [1:0]        wrBufBusy,
  input  logic              reqValid,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic              reqWrite,
  input  logic              iordy,
  output logic              busy,
  output logic              done,
  output logic              diorN,
  output logic              diowN
);

  pio_ctl_s ctl;
  logic     cntDone, stall, curWrite;

  pio_timer_datapath #(
    .NUM_UNITS(NUM_UNITS), .DEV_PER_CHAN(DEV_PER_CHAN), .CHAN_W(CHAN_W),
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .TIMING_BASE(TIMING_BASE),
    .ENABLE_ADDR(ENABLE_ADDR), .STATUS_ADDR(STATUS_ADDR),
    .ENABLE_SHIFT(ENABLE_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wrBufBusy(wrBufBusy),
    .reqChan(reqChan), .reqDev(reqDev), .reqWrite(reqWrite), .iordy(iordy),
    .ctl(ctl), .cntDone(cntDone), .stall(stall), .curWrite(curWrite)
  );

  pio_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cntDone(cntDone),
    .stall(stall), .curWrite(curWrite), .ctl(ctl), .busy(busy),
    .done(done), .diorN(diorN), .diowN(diowN)
  );

endmodule

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] wrBufBusy = '0;
  logic       reqValid = 1'b0;
  logic       reqChan = 1'b0;
  logic       reqDev = 1'b0;
  logic       reqWrite = 1'b0;
  logic       iordy = 1'b1;
  logic       busy, done, diorN, diowN;

  int checks = 0;
  int failures = 0;
  int measLow, measRec;
  bit measOther, measDone;
  logic [7:0] tbl [8];

  localparam logic [7:0] EN_A = 8'h0C;
  localparam logic [7:0] ST_A = 8'h0D;

  always #2 clk = ~clk;

  pio_strobe_timer u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wrBufBusy(wrBufBusy),
    .reqValid(reqValid), .reqChan(reqChan), .reqDev(reqDev),
    .reqWrite(reqWrite), .iordy(iordy), .busy(busy), .done(done),
    .diorN(diorN), .diowN(diowN)
  );

  function automatic int actOf(logic [7:0] b); return 17 - int'(b[3:0]); endfunction
  function automatic int recOf(logic [7:0] b); return 16 - int'(b[7:4]); endfunction
  function automatic logic [7:0] tAddr(int unit, bit hi); return 8'(8'h20 + 2 * unit + int'(hi)); endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // one PIO cycle, measured at negedges; optional register write on the accepting edge
  task automatic runCycle(int chan, int dev, bit wr, int stallLen, bit holdReq,
                          bit doWr, logic [7:0] wAddr, logic [7:0] wData);
    bit stallStarted;
    int left;
    logic strobe, other;
    stallStarted = 0; left = 0;
    @(negedge clk);
    reqValid = 1'b1; reqChan = chan[0]; reqDev = dev[0]; reqWrite = wr;
    if (doWr) begin regWrEn = 1'b1; regAddr = wAddr; regWrData = wData; end
    @(posedge clk);
    measLow = 0; measRec = 0; measOther = 0; measDone = 0;
    for (int k = 0; k < 400 && !measDone; k++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      if (holdReq && k < 2) begin reqChan = ~reqChan; reqWrite = ~wr; end
      else reqValid = 1'b0;
      strobe = wr ? diowN : diorN;
      other  = wr ? diorN : diowN;
      if (!other) measOther = 1;
      if (done && !busy) measDone = 1;
      else if (!strobe) measLow++;
      else if (busy) measRec++;
      if (stallLen > 0 && !stallStarted && measLow == 1) begin
        iordy = 1'b0; stallStarted = 1; left = stallLen;
      end else if (!iordy) begin
        left--;
        if (left == 0) iordy = 1'b1;
      end
    end
    reqWrite = 1'b0;
  endtask

  task automatic expectCycle(string tag, int expLow, int expRec);
    check(measDone, {tag, " done"}, int'(measDone), 1);
    check(measLow == expLow, {tag, " active"}, measLow, expLow);
    check(measRec == expRec, {tag, " recovery"}, measRec, expRec);
    check(!measOther, {tag, " other strobe"}, int'(measOther), 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(diorN && diowN, "R1 strobes high", int'({diorN, diowN}), 3);
    check(!busy && !done, "R1 busy/done low", int'({busy, done}), 0);
    for (int a = 0; a < 8; a++) begin
      regRead(8'(8'h20 + a), d);
      check(d == 8'h00, "R1 timing byte", int'(d), 0);
    end
    regRead(EN_A, d);
    check(d == 8'h00, "R1 enable byte", int'(d), 0);
    runCycle(0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    expectCycle("R1 R11 reset timing", 17, 16);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    tbl[0] = 8'hE9; tbl[1] = 8'hCB; tbl[2] = 8'hDC; tbl[3] = 8'hBA;
    tbl[4] = 8'hFE; tbl[5] = 8'hAD; tbl[6] = 8'h9F; tbl[7] = 8'hF0;
    for (int a = 0; a < 8; a++) regWrite(8'(8'h20 + a), tbl[a]);
    for (int a = 0; a < 8; a++) begin
      regRead(8'(8'h20 + a), d);
      check(d == tbl[a], "R2 timing readback", int'(d), int'(tbl[a]));
    end
  endtask

  task automatic t_units;
    for (int u = 0; u < 4; u++) begin
      runCycle(u / 2, u % 2, 0, 0, 0, 0, 8'h00, 8'h00);
      expectCycle("R3 R6 read", actOf(tbl[2*u]), recOf(tbl[2*u]));
      runCycle(u / 2, u % 2, 1, 0, 0, 0, 8'h00, 8'h00);
      expectCycle("R4 R6 write", actOf(tbl[2*u+1]), recOf(tbl[2*u+1]));
    end
  endtask

  task automatic t_busyIgnore;
    runCycle(1, 1, 0, 0, 1, 0, 8'h00, 8'h00);
    expectCycle("R5 held request", actOf(tbl[6]), recOf(tbl[6]));
    @(negedge clk);
    @(negedge clk);
    check(!busy && diorN && diowN, "R5 no extra cycle", int'(busy), 0);
  endtask

  task automatic t_iordy;
    runCycle(0, 1, 0, 3, 0, 0, 8'h00, 8'h00);
    expectCycle("R7 stretch", actOf(tbl[2]) + 3, recOf(tbl[2]));
    regWrite(EN_A, 8'h20);
    runCycle(0, 1, 0, 3, 0, 0, 8'h00, 8'h00);
    expectCycle("R8 iordy ignored", actOf(tbl[2]), recOf(tbl[2]));
    runCycle(0, 0, 0, 2, 0, 0, 8'h00, 8'h00);
    expectCycle("R7 other unit honours", actOf(tbl[0]) + 2, recOf(tbl[0]));
  endtask

  task automatic t_hold;
    logic [7:0] d;
    wrBufBusy = 2'b01;
    regRead(ST_A, d);
    check(d == 8'h01, "R9 status bit0", int'(d), 1);
    regWrite(EN_A, 8'h00);
    regRead(EN_A, d);
    check(d == 8'h20, "R9 held while bit0", int'(d), 32);
    wrBufBusy = 2'b10;
    regRead(ST_A, d);
    check(d == 8'h02, "R9 status bit1", int'(d), 2);
    regRead(EN_A, d);
    check(d == 8'h20, "R9 held while bit1", int'(d), 32);
    // still held: unit1 must ignore iordy
    runCycle(0, 1, 0, 2, 0, 0, 8'h00, 8'h00);
    expectCycle("R9 old enable in force", actOf(tbl[2]), recOf(tbl[2]));
    @(negedge clk);
    wrBufBusy = 2'b00;
    regAddr = EN_A;
    @(negedge clk);
    check(regRdData == 8'h00, "R9 released", int'(regRdData), 0);
    runCycle(0, 1, 0, 2, 0, 0, 8'h00, 8'h00);
    expectCycle("R9 new enable in force", actOf(tbl[2]) + 2, recOf(tbl[2]));
  endtask

  task automatic t_collide;
    runCycle(0, 0, 0, 0, 0, 1, tAddr(0, 0), 8'hFB);
    expectCycle("R10 same-edge write keeps old", actOf(tbl[0]), recOf(tbl[0]));
    runCycle(0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    expectCycle("R10 next cycle uses new", actOf(8'hFB), recOf(8'hFB));
  endtask

  task automatic t_extreme;
    regWrite(tAddr(2, 0), 8'hFF);
    regWrite(tAddr(2, 1), 8'h00);
    runCycle(1, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    expectCycle("R11 fastest", 2, 1);
    runCycle(1, 0, 1, 0, 0, 0, 8'h00, 8'h00);
    expectCycle("R11 slowest", 17, 16);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_units();
    t_busyIgnore();
    t_iordy();
    t_hold();
    t_collide();
    t_extreme();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule